// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block decides when a DRAM device is owed an auto-refresh and holds the banks unavailable while one runs. A free-running interval timer counts a programmable number of memory clocks. Each time it expires, one refresh is added to a backlog. The timer halves its period while the device reports a high temperature, which keeps every row inside the shorter retention window a hot die allows.

The backlog is offered to the command arbiter as a valid/ready pair. `ref_req_o` is the valid and `ref_gnt_i` is the ready. A refresh is issued on a clock edge where both are high. The arbiter may hold `ref_gnt_i` low for as long as it likes: owed refreshes simply pile up in the backlog, and the request does not drop. A grant presented while the request is low has no effect.

Every issued refresh starts a busy window of a programmable length. While that window is open, `banks_busy_o` is high and the request is withheld. When the backlog reaches a fixed threshold, an urgent flag tells the arbiter to place the refresh ahead of all other traffic.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held, and on the first cycle after it, `ref_req_o`, `ref_urgent_o` and `banks_busy_o` are 0 and `pend_cnt_o` is 0.
- R2: With `hot_i` low and `interval_i` = L (L >= 2), the timer expires once every L cycles. The first expiry adds one to `pend_cnt_o` on the (L+1)-th rising edge after reset is released, and each later expiry does the same L edges after the previous one.
- R3: With `hot_i` high, the period is floor(L/2) cycles. Any effective period below 2, hot or not, is raised to 2.
- R4: `hot_i` and `interval_i` are sampled only when the timer reloads. A change never shortens or stretches an interval already in progress.
- R5: `ref_req_o` is high exactly when `pend_cnt_o` is non-zero and `banks_busy_o` is low. A refresh is issued on an edge where `ref_req_o` and `ref_gnt_i` are both high. `ref_gnt_i` while `ref_req_o` is low changes nothing.
- R6: An issued refresh lowers `pend_cnt_o` by one. An expiry and an issue on the same edge leave the count unchanged.
- R7: After an issue, `banks_busy_o` is high for exactly `rfc_i` cycles, starting on the next edge. A value of 0 is treated as 1.
- R8: `pend_cnt_o` saturates at 2^PEND_W - 1. Expiries that arrive at that value are dropped.
- R9: `ref_urgent_o` is high exactly when `pend_cnt_o` >= MAX_PEND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Device above the high-temperature threshold |
| interval_i | input | CNT_W | Refresh interval in clock cycles at normal temperature |
| rfc_i | input | RFC_W | Busy window length in cycles per refresh |
| ref_gnt_i | input | 1 | Arbiter accepts the refresh (ready) |
| ref_req_o | output | 1 | Refresh owed and banks free (valid) |
| ref_urgent_o | output | 1 | Backlog at or above the urgent threshold |
| banks_busy_o | output | 1 | Banks unavailable, refresh in progress |
| pend_cnt_o | output | PEND_W | Number of owed refreshes |

## Verification
Each result has a fixed latency, and the checks are placed to match it:
- **Expiry:** becomes visible in `pend_cnt_o` one edge after the timer reaches its last count, so the first increment lands on edge L+1 after reset is released.
- **Grant:** lowers the count and raises `banks_busy_o` on the very next edge.
- **Request and urgent flag:** combinational functions of registered state, so they follow in the same cycle.

The bench drives inputs and compares outputs only on falling edges. An arithmetic model of the requirements advances on each rising edge. Every output is therefore compared once per cycle, half a period after the edge that made it. A directed check brackets the first expiry at cycles L and L+1.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  // Events that move the refresh backlog on one clock edge.
  typedef struct packed {
    logic expire;  // interval timer ran out
    logic issue;   // arbiter accepted a refresh
  } refsched_evt_t;
endpackage

// File: rtl/refsched_interval.sv
module refsched_interval #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hot_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(2);

  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] halved;
  logic [CNT_W-1:0] next_len;

  // Period for the next interval; only consumed when the timer reloads.
  always_comb begin
    halved   = interval_i >> 1;
    next_len = hot_i ? halved : interval_i;
    if (next_len < MIN_LEN) next_len = MIN_LEN;
  end

  assign expire_o = (remain_q == CNT_W'(1));

  // remain_q == 0 only right after reset: load without expiring.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                      remain_q <= '0;
    else if (remain_q <= CNT_W'(1))   remain_q <= next_len;
    else                              remain_q <= remain_q - CNT_W'(1);
  end
endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog
  import refsched_pkg::*;
#(
  parameter int PEND_W   = 4,
  parameter int MAX_PEND = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  refsched_evt_t     evt_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              owed_o,
  output logic              urgent_o
);
  localparam logic [PEND_W-1:0] PEND_CAP = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      unique case ({evt_i.expire, evt_i.issue})
        2'b10:   if (pend_q != PEND_CAP) pend_q <= pend_q + PEND_W'(1);
        2'b01:   if (pend_q != '0)       pend_q <= pend_q - PEND_W'(1);
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign pend_o   = pend_q;
  assign owed_o   = (pend_q != '0);
  assign urgent_o = (32'(pend_q) >= MAX_PEND);
endmodule

// File: rtl/refsched_busy.sv
module refsched_busy #(
  parameter int RFC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [RFC_W-1:0] rfc_i,
  output logic             busy_o
);
  logic [RFC_W-1:0] left_q;
  logic [RFC_W-1:0] load_len;

  assign load_len = (rfc_i == '0) ? RFC_W'(1) : rfc_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)             left_q <= '0;
    else if (issue_i)        left_q <= load_len;
    else if (left_q != '0)   left_q <= left_q - RFC_W'(1);
  end

  assign busy_o = (left_q != '0);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RFC_W    = 10,
  parameter int PEND_W   = 4,
  parameter int MAX_PEND = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hot_i,
  input  logic [CNT_W-1:0]  interval_i,
  input  logic [RFC_W-1:0]  rfc_i,
  input  logic              ref_gnt_i,
  output logic              ref_req_o,
  output logic              ref_urgent_o,
  output logic              banks_busy_o,
  output logic [PEND_W-1:0] pend_cnt_o
);
  logic          expire;
  logic          owed;
  logic          busy;
  logic          issue;
  refsched_evt_t evt;

  refsched_interval #(.CNT_W(CNT_W)) u_interval (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hot_i      (hot_i),
    .interval_i (interval_i),
    .expire_o   (expire)
  );

  // Valid/ready: valid while owed and banks free; a grant alone does nothing.
  assign ref_req_o = owed & ~busy;
  assign issue     = ref_req_o & ref_gnt_i;

  assign evt.expire = expire;
  assign evt.issue  = issue;

  refsched_backlog #(.PEND_W(PEND_W), .MAX_PEND(MAX_PEND)) u_backlog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .pend_o   (pend_cnt_o),
    .owed_o   (owed),
    .urgent_o (ref_urgent_o)
  );

  refsched_busy #(.RFC_W(RFC_W)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .rfc_i   (rfc_i),
    .busy_o  (busy)
  );

  assign banks_busy_o = busy;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int PEND_W   = 4,
  parameter int MAX_PEND = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ref_gnt_i,
  input logic              ref_req_o,
  input logic              ref_urgent_o,
  input logic              banks_busy_o,
  input logic [PEND_W-1:0] pend_cnt_o
);
  AST_REQ_NEEDS_BACKLOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> (pend_cnt_o != '0)); // R5

  AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_gnt_i) |=> banks_busy_o); // R7

  AST_BUSY_ONLY_FROM_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(banks_busy_o) |-> $past(ref_req_o && ref_gnt_i)); // R7

  AST_ISSUE_NO_GROWTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_gnt_i) |=> (pend_cnt_o <= $past(pend_cnt_o))); // R6

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ({1'b0, pend_cnt_o} <= ({1'b0, $past(pend_cnt_o)} + 1'b1))); // R2

  AST_URGENT_HAS_BACKLOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_urgent_o |-> (pend_cnt_o != '0)); // R9
endmodule

bind refresh_sched refresh_sched_chk #(.PEND_W(PEND_W), .MAX_PEND(MAX_PEND)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ref_gnt_i    (ref_gnt_i),
  .ref_req_o    (ref_req_o),
  .ref_urgent_o (ref_urgent_o),
  .banks_busy_o (banks_busy_o),
  .pend_cnt_o   (pend_cnt_o)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int CNT_W    = 8;
  localparam int RFC_W    = 4;
  localparam int PEND_W   = 3;
  localparam int MAX_PEND = 5;
  localparam int PEND_CAP = (1 << PEND_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hot = 1'b0;
  logic              gnt = 1'b0;
  logic [CNT_W-1:0]  ivl = 8'd10;
  logic [RFC_W-1:0]  rfc = 4'd2;
  logic              req, urgent, busy;
  logic [PEND_W-1:0] pend;

  int checks = 0;
  int errors = 0;

  // Requirement model state
  int m_tmr = 0;
  int m_pend = 0;
  int m_busy = 0;

  always #4 clk = ~clk;  // 125 MHz

  refresh_sched #(.CNT_W(CNT_W), .RFC_W(RFC_W), .PEND_W(PEND_W), .MAX_PEND(MAX_PEND)) u_refresh_sched (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .hot_i        (hot),
    .interval_i   (ivl),
    .rfc_i        (rfc),
    .ref_gnt_i    (gnt),
    .ref_req_o    (req),
    .ref_urgent_o (urgent),
    .banks_busy_o (busy),
    .pend_cnt_o   (pend)
  );

  // Arithmetic model of R2..R9, advanced on each rising edge.
  always @(posedge clk) begin : model
    int  eff;
    bit  ex;
    bit  iss;
    if (!rst_n) begin
      m_tmr = 0; m_pend = 0; m_busy = 0;
    end else begin
      eff = hot ? (int'(ivl) / 2) : int'(ivl);   // R3
      if (eff < 2) eff = 2;
      ex  = (m_tmr == 1);
      iss = (m_pend != 0) && (m_busy == 0) && gnt; // R5
      if (m_tmr <= 1) m_tmr = eff; else m_tmr = m_tmr - 1; // R4: sampled at reload only
      if (ex && !iss) begin
        if (m_pend < PEND_CAP) m_pend = m_pend + 1;        // R8
      end else if (!ex && iss) begin
        m_pend = m_pend - 1;                               // R6
      end
      if (iss) m_busy = (rfc == 0) ? 1 : int'(rfc);        // R7
      else if (m_busy > 0) m_busy = m_busy - 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int e_req;
    int e_urg;
    e_req = (m_pend != 0 && m_busy == 0) ? 1 : 0;
    e_urg = (m_pend >= MAX_PEND) ? 1 : 0;
    check(int'(pend) == m_pend, "R2/R3/R4/R6/R8 pend_cnt", int'(pend), m_pend);
    check(int'(req) == e_req, "R5 ref_req", int'(req), e_req);
    check(int'(busy) == (m_busy != 0 ? 1 : 0), "R7 banks_busy", int'(busy), (m_busy != 0 ? 1 : 0));
    check(int'(urgent) == e_urg, "R9 ref_urgent", int'(urgent), e_urg);
  endtask

  task automatic reset_quiet_check();
    check(req == 1'b0, "R1 req in reset", int'(req), 0);
    check(urgent == 1'b0, "R1 urgent in reset", int'(urgent), 0);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(pend == '0, "R1 pend in reset", int'(pend), 0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    gnt   = 1'b0;
    repeat (2) @(negedge clk);
    reset_quiet_check();
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    // R1 and R2 directed: L = 10, no grants, first increment on edge 11.
    ivl = 8'd10; rfc = 4'd2; hot = 1'b0;
    apply_reset();
    repeat (10) @(negedge clk);
    check(pend == '0, "R2 no increment by edge L", int'(pend), 0);
    @(negedge clk);
    check(pend == 3'd1, "R2 first increment on edge L+1", int'(pend), 1);
    check(req == 1'b1, "R5 request raised with backlog", int'(req), 1);

    // Sweep: temperature start, interval, busy length, grant pattern.
    for (int h = 0; h < 2; h++) begin
      for (int li = 0; li < 5; li++) begin
        for (int r = 0; r < 3; r++) begin
          for (int p = 0; p < 3; p++) begin
            case (li)
              0: ivl = 8'd2;
              1: ivl = 8'd3;
              2: ivl = 8'd5;
              3: ivl = 8'd8;
              default: ivl = 8'd13;
            endcase
            case (r)
              0: rfc = 4'd0;
              1: rfc = 4'd1;
              default: rfc = 4'd3;
            endcase
            hot = h[0];
            apply_reset();
            for (int k = 0; k < 90; k++) begin
              // R4: temperature flips mid-interval at k = 37
              hot = h[0] ^ (k >= 37);
              case (p)
                0: gnt = 1'b1;
                1: gnt = (k >= 60);        // R8/R9 backlog build-up
                default: gnt = (k % 3 == 0);
              endcase
              @(negedge clk);
              compare_all();
            end
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule